// File: doc/BRIEF.md
# Chainable Triggered Event Counter Array

This block holds a small bank of event counters, four by default, each 32 bits wide. Each counter has its own event strobe. A counter can instead be set to count the wraps of the counter just below it. Chaining counters this way builds one long count out of several words: counter 1 extends counter 0, counter 2 extends counter 1, and so on. Each link in the chain adds one cycle of delay. An upper word can therefore trail the true combined count for a few cycles after a wrap.

A counter can also be started, stopped or toggled by activity on any counter in the bank. That activity is either a single increment or a wrap. This lets software bracket a measurement window with another counter's events. Each counter can raise an interrupt once its top bit becomes set. The interrupt stays raised until software writes that counter with a value whose top bit is clear.

Software reaches the block through one write port. A select bit chooses between a counter's value and its control word. The control word is laid out as follows:

| Bits | Field |
|------|-------|
| 0 | freeze |
| 1 | event select: 0 = own strobe, 1 = chain from the counter below |
| 3:2 | trigger mode |
| 4 | trigger kind: 0 = increment, 1 = wrap |
| 5 | interrupt enable |
| 7:6 | trigger source index |

Top module: `evt_counter_array`

## Requirements
- R1: While `rst_n` is low, every counter reads 0 and `irq` is low. Every control word is 0, so each counter runs and counts its own strobe.
- R2: A counter with event select 0 that is running and not frozen adds one in the cycle after each clock edge at which its `evt_in` bit is high.
- R3: When the freeze bit (control bit 0) is 1, the counter holds its value whatever its strobe does.
- R4: A counter i > 0 with event select 1 adds exactly one, one cycle after counter i−1 wraps from all ones to zero. Counter i−1 gaining its top bit without wrapping leaves counter i unchanged.
- R5: Counter 0 has no chain source. With event select 1 it never counts.
- R6: A wrap ripples up a chain with one cycle per link. In a chain of preloaded all-ones words, counter k wraps k cycles after counter 0 wraps.
- R7: The trigger mode (bits 3:2) behaves as follows. 00 ignores triggers. 01 starts the counter. 10 stops it. 11 toggles run and stop. Writing a control word with mode 01 leaves the counter stopped until it is triggered. Writing any other mode leaves it running. A stopped counter holds its value.
- R8: The trigger source is the counter named in bits 7:6. The trigger kind (bit 4) picks the event: 0 means that source incremented, 1 means it wrapped. Suppose the source changes at edge a. The target's run state then changes at edge a+1, and a started target first counts at edge a+2.
- R9: Writing a counter's value takes effect at that edge and overrides any increment in the same cycle. A write is neither an increment nor a wrap for chaining or triggering.
- R10: Each counter keeps a sticky flag. The flag sets when the counter's top bit becomes 1 and survives a later wrap. It clears only when the counter is written with top bit 0. `irq` is the OR of the flags whose interrupt enable (bit 5) is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | NUM_CNT | Per-counter event strobes |
| wr_en | input | 1 | Write strobe |
| wr_ctl | input | 1 | 1 = write the control word, 0 = write the counter value |
| wr_idx | input | clog2(NUM_CNT) | Index of the counter to write |
| wr_data | input | CNT_W | Write data; the control word uses the low bits |
| cnt_val | output | NUM_CNT*CNT_W | All counter values, counter i in slice i |
| irq | output | 1 | Interrupt: OR of enabled sticky top-bit flags |

## Verification
The bench drives chains through a full ripple from preloaded all-ones words and checks how far the upper words lag each cycle. A design that chains on the top bit becoming set, rather than on a true wrap, bumps the next word too early and is caught by the top-bit preload case. The bench also lands a strobe and a write in the same cycle, starts a counter through a trigger with the two-cycle delay, and stops a counter on another counter's wrap. A wrong write priority, a trigger taken one cycle too soon, or a write that is wrongly treated as a change each throws the cycle-by-cycle model comparison off. The interrupt case wraps a flagged counter through zero, which exposes an `irq` that simply follows the live top bit.

// File: rtl/evctr_pkg.sv
package evctr_pkg;

   // control word bit positions
   localparam int FRZ_B   = 0;
   localparam int CHN_B   = 1;
   localparam int MODE_LO = 2;
   localparam int KIND_B  = 4;
   localparam int IE_B    = 5;
   localparam int SRC_LO  = 6;

   typedef enum logic [1:0] {
      TRG_NONE   = 2'b00,
      TRG_START  = 2'b01,
      TRG_STOP   = 2'b10,
      TRG_TOGGLE = 2'b11
   } trg_mode_e;

   // run state after a trigger hit under a given mode
   function automatic logic run_after_hit(trg_mode_e m, logic run);
      logic r;
      case (m)
         TRG_START:  r = 1'b1;
         TRG_STOP:   r = 1'b0;
         TRG_TOGGLE: r = ~run;
         default:    r = run;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/evctr_trig_sel.sv
module evctr_trig_sel #(
   parameter int NUM_CNT = 4,
   parameter int IDX_W   = 2
) (
   input  logic [NUM_CNT-1:0] inc_v,
   input  logic [NUM_CNT-1:0] ovf_v,
   input  logic [IDX_W-1:0]   src,
   input  logic               kind,
   output logic               hit
);
   logic [NUM_CNT-1:0] pick_v;

   always_comb begin
      pick_v = kind ? ovf_v : inc_v;
      hit    = 1'b0;
      for (int j = 0; j < NUM_CNT; j++) begin
         if (src == IDX_W'(j)) hit = pick_v[j];
      end
   end
endmodule

// File: rtl/evctr_cell.sv
module evctr_cell
   import evctr_pkg::*;
#(
   parameter int CNT_W = 32,
   parameter int IDX_W = 2,
   parameter int CTL_W = 8,
   parameter int IDX   = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt,
   input  logic             chain_ovf,
   input  logic             trig_hit,
   input  logic             wr_en,
   input  logic             wr_ctl,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CTL_W-1:0] ctl_o,
   output logic             inc_o,
   output logic             ovf_o,
   output logic             flag_o
);
   logic [CNT_W-1:0] cnt_q, cnt_nx;
   logic [CTL_W-1:0] ctl_q;
   logic             run_q, inc_q, ovf_q, flag_q;
   logic             hit_me, wr_val, wr_cw, src_evt, cnt_en;
   trg_mode_e        mode_now, mode_new;

   always_comb begin
      hit_me   = (wr_idx == IDX_W'(IDX));
      wr_val   = wr_en & ~wr_ctl & hit_me;
      wr_cw    = wr_en &  wr_ctl & hit_me;
      mode_now = trg_mode_e'(ctl_q[MODE_LO +: 2]);
      mode_new = trg_mode_e'(wr_data[MODE_LO +: 2]);
      src_evt  = ctl_q[CHN_B] ? chain_ovf : evt;
      cnt_en   = run_q & ~ctl_q[FRZ_B] & src_evt & ~wr_val;
      if (wr_val)      cnt_nx = wr_data;
      else if (cnt_en) cnt_nx = cnt_q + CNT_W'(1);
      else             cnt_nx = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         ctl_q  <= '0;
         run_q  <= 1'b1;
         inc_q  <= 1'b0;
         ovf_q  <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_nx;
         inc_q  <= cnt_en;
         ovf_q  <= cnt_en & (&cnt_q);
         flag_q <= wr_val ? wr_data[CNT_W-1] : (flag_q | cnt_nx[CNT_W-1]);
         if (wr_cw) begin
            ctl_q <= wr_data[CTL_W-1:0];
            run_q <= (mode_new != TRG_START);
         end else if (trig_hit) begin
            run_q <= run_after_hit(mode_now, run_q);
         end
      end
   end

   assign cnt_o  = cnt_q;
   assign ctl_o  = ctl_q;
   assign inc_o  = inc_q;
   assign ovf_o  = ovf_q;
   assign flag_o = flag_q;
endmodule

// File: rtl/evctr_irq.sv
module evctr_irq #(
   parameter int NUM_CNT = 4
) (
   input  logic [NUM_CNT-1:0] flag_v,
   input  logic [NUM_CNT-1:0] ie_v,
   output logic               irq
);
   assign irq = |(flag_v & ie_v);
endmodule

// File: rtl/evt_counter_array.sv
module evt_counter_array
   import evctr_pkg::*;
#(
   parameter int NUM_CNT  = 4,
   parameter int CNT_W    = 32,
   parameter bit CHAIN_EN = 1'b1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_CNT-1:0]              evt_in,
   input  logic                            wr_en,
   input  logic                            wr_ctl,
   input  logic [$clog2(NUM_CNT)-1:0]      wr_idx,
   input  logic [CNT_W-1:0]                wr_data,
   output logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_val,
   output logic                            irq
);
   localparam int IDX_W = $clog2(NUM_CNT);
   localparam int CTL_W = SRC_LO + IDX_W;

   initial begin
      assert (NUM_CNT >= 2) else $error("NUM_CNT must be at least 2");
      assert (CNT_W >= CTL_W) else $error("CNT_W too narrow for control word");
   end

   logic [NUM_CNT-1:0][CTL_W-1:0] ctl_all;
   logic [NUM_CNT-1:0] inc_v, ovf_v, flag_v, ie_v, chain_in, hit_v;

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
      if (i == 0 || !CHAIN_EN) begin : g_nochain
         assign chain_in[i] = 1'b0;
      end else begin : g_chain
         assign chain_in[i] = ovf_v[i-1];
      end

      evctr_trig_sel #(.NUM_CNT(NUM_CNT), .IDX_W(IDX_W)) u_sel (
         .inc_v (inc_v),
         .ovf_v (ovf_v),
         .src   (ctl_all[i][SRC_LO +: IDX_W]),
         .kind  (ctl_all[i][KIND_B]),
         .hit   (hit_v[i])
      );

      evctr_cell #(.CNT_W(CNT_W), .IDX_W(IDX_W), .CTL_W(CTL_W), .IDX(i)) u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .evt       (evt_in[i]),
         .chain_ovf (chain_in[i]),
         .trig_hit  (hit_v[i]),
         .wr_en     (wr_en),
         .wr_ctl    (wr_ctl),
         .wr_idx    (wr_idx),
         .wr_data   (wr_data),
         .cnt_o     (cnt_val[i]),
         .ctl_o     (ctl_all[i]),
         .inc_o     (inc_v[i]),
         .ovf_o     (ovf_v[i]),
         .flag_o    (flag_v[i])
      );

      assign ie_v[i] = ctl_all[i][IE_B];
   end

   evctr_irq #(.NUM_CNT(NUM_CNT)) u_irq (
      .flag_v (flag_v),
      .ie_v   (ie_v),
      .irq    (irq)
   );
endmodule

// File: rtl/evctr_chk.sv
module evctr_chk
   import evctr_pkg::*;
#(
   parameter int NUM_CNT = 4,
   parameter int CNT_W   = 32,
   parameter int IDX_W   = 2,
   parameter int CTL_W   = 8
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          wr_en,
   input logic                          wr_ctl,
   input logic [IDX_W-1:0]              wr_idx,
   input logic [CNT_W-1:0]              wr_data,
   input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_val,
   input logic [NUM_CNT-1:0][CTL_W-1:0] ctl_all,
   input logic                          irq
);
   logic [NUM_CNT-1:0] ie_v, wval_v;

   always_comb begin
      for (int i = 0; i < NUM_CNT; i++) begin
         ie_v[i]   = ctl_all[i][IE_B];
         wval_v[i] = wr_en & ~wr_ctl & (wr_idx == IDX_W'(i));
      end
   end

   // R1
   rst_zero_chk: assert property (@(posedge clk)
      !rst_n |=> (cnt_val == '0 && !irq));

   // R5
   head_nochain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_all[0][CHN_B] && !wval_v[0]) |=> $stable(cnt_val[0]));

   // R10
   irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ie_v == '0) |-> !irq);

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
      // R9
      wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         wval_v[i] |=> (cnt_val[i] == $past(wr_data)));

      // R2
      single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !wval_v[i] |=> (cnt_val[i] == $past(cnt_val[i]) ||
                         cnt_val[i] == $past(cnt_val[i]) + CNT_W'(1)));

      // R3
      freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ctl_all[i][FRZ_B] && !wval_v[i]) |=> $stable(cnt_val[i]));
   end
endmodule

bind evt_counter_array evctr_chk #(
   .NUM_CNT (NUM_CNT),
   .CNT_W   (CNT_W),
   .IDX_W   (IDX_W),
   .CTL_W   (CTL_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_ctl  (wr_ctl),
   .wr_idx  (wr_idx),
   .wr_data (wr_data),
   .cnt_val (cnt_val),
   .ctl_all (ctl_all),
   .irq     (irq)
);

// File: tb/sim_evt_counter_array.sv
module sim_evt_counter_array;
   localparam int N = 4;
   localparam int W = 32;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic                 rst_n;
   logic [N-1:0]         evt;
   logic                 wr_en, wr_ctl;
   logic [1:0]           wr_idx;
   logic [W-1:0]         wr_data;
   logic [N-1:0][W-1:0]  cnt_val;
   logic                 irq;

   evt_counter_array #(.NUM_CNT(N), .CNT_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .evt_in(evt), .wr_en(wr_en), .wr_ctl(wr_ctl),
      .wr_idx(wr_idx), .wr_data(wr_data), .cnt_val(cnt_val), .irq(irq)
   );

   int    n_chk  = 0;
   int    n_fail = 0;
   bit    done   = 0;
   string phase  = "R1 reset";

   // behavioural reference state
   logic [W-1:0] m_cnt [N];
   logic [7:0]   m_ctl [N];
   bit           m_run [N], m_inc [N], m_ovf [N], m_flag [N];
   logic [W-1:0] t_cnt [N];
   logic [7:0]   t_ctl [N];
   bit           t_run [N], t_inc [N], t_ovf [N], t_flag [N];

   function automatic bit m_irq();
      bit r = 0;
      for (int k = 0; k < N; k++) r |= m_flag[k] & m_ctl[k][5];
      return r;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < N; k++) begin
            m_cnt[k] = '0; m_ctl[k] = '0; m_run[k] = 1;
            m_inc[k] = 0;  m_ovf[k] = 0;  m_flag[k] = 0;
         end
      end else begin
         for (int k = 0; k < N; k++) begin
            bit wv, wc, src, go, hit;
            int s;
            wv  = wr_en && !wr_ctl && (int'(wr_idx) == k);
            wc  = wr_en &&  wr_ctl && (int'(wr_idx) == k);
            src = m_ctl[k][1] ? ((k > 0) ? m_ovf[k-1] : 1'b0) : evt[k];
            go  = m_run[k] && !m_ctl[k][0] && src && !wv;
            s   = int'(m_ctl[k][7:6]);
            hit = m_ctl[k][4] ? m_ovf[s] : m_inc[s];
            if (wv)      t_cnt[k] = wr_data;
            else if (go) t_cnt[k] = m_cnt[k] + 1;
            else         t_cnt[k] = m_cnt[k];
            t_inc[k]  = go;
            t_ovf[k]  = go && (m_cnt[k] == '1);
            t_flag[k] = wv ? wr_data[W-1] : (m_flag[k] || t_cnt[k][W-1]);
            t_ctl[k]  = wc ? wr_data[7:0] : m_ctl[k];
            if (wc) t_run[k] = (wr_data[3:2] != 2'b01);
            else if (hit) begin
               case (m_ctl[k][3:2])
                  2'b01:   t_run[k] = 1;
                  2'b10:   t_run[k] = 0;
                  2'b11:   t_run[k] = !m_run[k];
                  default: t_run[k] = m_run[k];
               endcase
            end else t_run[k] = m_run[k];
         end
         for (int k = 0; k < N; k++) begin
            m_cnt[k] = t_cnt[k]; m_ctl[k] = t_ctl[k]; m_run[k] = t_run[k];
            m_inc[k] = t_inc[k]; m_ovf[k] = t_ovf[k]; m_flag[k] = t_flag[k];
         end
      end
   end

   task automatic check(input string tag, input bit ok,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic tick();
      bit bad = 0;
      @(negedge clk);
      n_chk++;
      for (int k = 0; k < N; k++) begin
         if (cnt_val[k] !== m_cnt[k]) begin
            bad = 1;
            $display("FAIL %s: counter %0d actual %h expected %h",
                     phase, k, cnt_val[k], m_cnt[k]);
         end
      end
      if (irq !== m_irq()) begin
         bad = 1;
         $display("FAIL %s: irq actual %b expected %b", phase, irq, m_irq());
      end
      if (bad) n_fail++;
   endtask

   task automatic put(input bit ctl, input int idx, input logic [W-1:0] d);
      wr_en = 1; wr_ctl = ctl; wr_idx = idx[1:0]; wr_data = d;
      tick();
      wr_en = 0; wr_ctl = 0;
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_up();
   end

   initial begin
      logic [W-1:0] keep;
      rst_n = 0; evt = '0; wr_en = 0; wr_ctl = 0; wr_idx = '0; wr_data = '0;
      repeat (3) @(negedge clk);
      check("R1 reset counters", cnt_val == '0, cnt_val[0], '0);
      check("R1 reset irq", irq == 1'b0, W'(irq), '0);
      rst_n = 1;

      phase = "R2 own event count";
      evt = 4'b1111;
      repeat (5) tick();
      check("R2 five strobes", cnt_val[3] == 5, cnt_val[3], 5);
      evt = 4'b0101; repeat (3) tick();
      evt = 4'b1010; repeat (3) tick();
      check("R2 alternating pattern", cnt_val[0] == 8, cnt_val[0], 8);

      phase = "R3 freeze";
      evt = '0;
      put(1, 1, 32'h1);
      keep = cnt_val[1];
      evt = 4'b1111; repeat (4) tick();
      check("R3 frozen counter holds", cnt_val[1] == keep, cnt_val[1], keep);
      evt = '0;
      put(1, 1, 32'h0);

      phase = "R9 write priority";
      evt = 4'b1111;
      put(0, 2, 32'h100);
      check("R9 write beats strobe", cnt_val[2] == 32'h100, cnt_val[2], 32'h100);
      evt = '0; tick();

      phase = "R4 R6 chain ripple";
      for (int k = 1; k < N; k++) put(1, k, 32'h02);
      put(0, 0, 32'hFFFF_FFFE);
      for (int k = 1; k < N; k++) put(0, k, 32'hFFFF_FFFF);
      evt = 4'b0001; tick(); tick();
      evt = '0; tick();
      check("R6 top word lags", cnt_val[3] == 32'hFFFF_FFFF, cnt_val[3], 32'hFFFF_FFFF);
      tick(); tick();
      check("R6 ripple settled", cnt_val[3] == 0 && cnt_val[2] == 0 && cnt_val[1] == 0,
            cnt_val[3], 0);
      put(0, 0, 32'h7FFF_FFFF);
      keep = cnt_val[1];
      evt = 4'b0001; tick();
      evt = '0; tick(); tick();
      check("R4 msb set without wrap", cnt_val[1] == keep, cnt_val[1], keep);

      phase = "R5 head chain select";
      put(1, 0, 32'h02);
      keep = cnt_val[0];
      evt = 4'b0001; repeat (4) tick();
      check("R5 counter 0 chain idle", cnt_val[0] == keep, cnt_val[0], keep);
      evt = '0;
      for (int k = 0; k < N; k++) put(1, k, 32'h0);

      phase = "R7 R8 start on change";
      put(1, 2, 32'h04);
      keep = cnt_val[2];
      evt = 4'b0100; repeat (3) tick();
      check("R7 start mode waits", cnt_val[2] == keep, cnt_val[2], keep);
      evt = 4'b0101; tick();
      evt = 4'b0100; tick();
      check("R8 not yet counting", cnt_val[2] == keep, cnt_val[2], keep);
      tick();
      check("R8 counts two edges on", cnt_val[2] == keep + 1, cnt_val[2], keep + 1);

      phase = "R7 R8 stop on wrap";
      evt = '0;
      put(1, 3, 32'h58);
      put(0, 1, 32'hFFFF_FFFF);
      evt = 4'b1000; repeat (2) tick();
      evt = 4'b1010; tick();
      evt = 4'b1000; tick(); tick();
      keep = cnt_val[3];
      repeat (3) tick();
      check("R7 stopped holds", cnt_val[3] == keep, cnt_val[3], keep);

      phase = "R7 toggle";
      evt = '0;
      put(1, 0, 32'h4C);
      evt = 4'b0011; repeat (8) tick();
      evt = '0;
      for (int k = 0; k < N; k++) put(1, k, 32'h0);

      phase = "R10 sticky irq";
      put(1, 0, 32'h20);
      put(0, 0, 32'h7FFF_FFFF);
      check("R10 irq low before msb", irq == 0, W'(irq), 0);
      evt = 4'b0001; tick();
      check("R10 irq on msb", irq == 1, W'(irq), 1);
      evt = '0;
      put(0, 0, 32'hFFFF_FFFF);
      evt = 4'b0001; tick();
      evt = '0;
      check("R10 irq survives wrap", irq == 1 && cnt_val[0] == 0, W'(irq), 1);
      put(0, 0, 32'h5);
      check("R10 irq cleared by write", irq == 0, W'(irq), 0);
      put(0, 1, 32'h8000_0000);
      check("R10 disabled flag masked", irq == 0, W'(irq), 0);

      phase = "R2 R7 R8 R9 random mix";
      for (int c = 0; c < 400; c++) begin
         evt = N'($urandom);
         if (($urandom % 8) == 0) begin
            wr_en = 1; wr_ctl = $urandom % 2; wr_idx = 2'($urandom);
            wr_data = wr_ctl ? 32'($urandom % 256) : 32'($urandom);
         end else begin
            wr_en = 0;
         end
         tick();
      end
      wr_en = 0; evt = '0;
      finish_up();
   end
endmodule